// File: doc/BRIEF.md
# Programmable Clock Output with Separate High and Low Counts

This block drives a general-purpose pin with a clock made from a 24 MHz reference. Two 8-bit counts give the length of each output period. The first count is the number of reference cycles the pin stays high. The second is the number of cycles it then stays low. The output frequency is the reference divided by the sum of the two counts, and the duty cycle is set by their ratio. A 1:1 setting gives a square wave. A count of 1 on one side gives a single one-cycle pulse per period. With both counts at 255, the period is 510 cycles, which is about 47 kHz.

The counts are copied into shadow registers only at a period boundary, so changing them in the middle of a period never produces a short or broken period. Three settings do not divide:
- Both counts zero: the reference clock itself is routed to the pin.
- Only the low count zero: the pin is held high.
- Only the high count zero: the pin is held low.

In these three settings every reference cycle counts as a boundary, so a new setting is picked up at once. A pin-mode enable chooses whether the pin carries this clock or the ordinary GPIO output value.

Top module: `prog_clk_out`

## Requirements
- R1: When the active counts are high=0 and low=0, `pin_out` equals `clk_ref`: high while the reference is high and low while it is low.
- R2: For nonzero counts H and L, each period is exactly H reference cycles with `pin_out`=1, followed by exactly L cycles with `pin_out`=0.
- R3: A count of 1 on either side gives a one-cycle pulse: high for 1 cycle with H=1, or low for 1 cycle with L=1.
- R4: With H=255 and L=255, the period is 255 high cycles followed by 255 low cycles, 510 cycles in total.
- R5: With H nonzero and L=0, `pin_out` stays 1. With H=0 and L nonzero, `pin_out` stays 0.
- R6: Count changes made during a dividing period take effect only after that period has finished with its old counts.
- R7: With `clk_out_en`=0, `pin_out` equals `gpio_data`. With `clk_out_en`=1, `pin_out` carries the generated clock.
- R8: While `rst_n` is low, and until the first clock edge after reset is released, the active setting is "hold low". As a result `pin_out` is 0 when `clk_out_en`=1.
- R9: When the active setting does not divide (the bypass setting or either hold setting), new counts take effect at the next reference edge. A new dividing setting starts with its high phase in the first cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_ref | input | 1 | 24 MHz reference clock |
| rst_n | input | 1 | Asynchronous active-low reset; release is synchronized inside the block |
| high_cnt | input | 8 | Number of reference cycles high per period |
| low_cnt | input | 8 | Number of reference cycles low per period |
| clk_out_en | input | 1 | Pin-mode select: 1 = generated clock, 0 = GPIO value |
| gpio_data | input | 1 | Ordinary GPIO output value |
| pin_out | output | 1 | Pin drive value |

## Verification
The bench measures the high and low run lengths of the pin over settings that include square, narrow-pulse and longest-period cases.
- A counter that is off by one would give runs one cycle too long or too short.
- A shadow that loads at the wrong time would cut short the period in which the counts are changed mid-flight.
- A design that treats zero counts as dividing would give a run of 256 cycles, or a stuck pin, where the bench expects a constant level or the reference clock.

The bench also checks the first output cycle after leaving a hold setting. This catches a design that waits one extra period before switching, or that starts a new period in its low phase.

// File: rtl/prog_clk_out_pkg.sv
package prog_clk_out_pkg;

  // How the active pair of counts drives the pin.
  typedef enum logic [1:0] {
    MODE_DIVIDE  = 2'd0,
    MODE_HOLD_HI = 2'd1,
    MODE_HOLD_LO = 2'd2,
    MODE_BYPASS  = 2'd3
  } out_mode_e;

  function automatic out_mode_e classify(input logic hi_is_zero, input logic lo_is_zero);
    out_mode_e m;
    case ({hi_is_zero, lo_is_zero})
      2'b00:   m = MODE_DIVIDE;
      2'b01:   m = MODE_HOLD_HI;
      2'b10:   m = MODE_HOLD_LO;
      default: m = MODE_BYPASS;
    endcase
    return m;
  endfunction

endpackage

// File: rtl/prog_clk_out_rst_sync.sv
module prog_clk_out_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_async_n,
  output logic rst_sync_n
);

  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  always_comb begin
    chain_d = {chain_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_async_n) begin
    if (!rst_async_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= chain_d;
    end
  end

  assign rst_sync_n = chain_q[STAGES-1];

endmodule

// File: rtl/prog_clk_out_shadow.sv
module prog_clk_out_shadow
  import prog_clk_out_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  output logic [CNT_W-1:0] hi_q,
  output logic [CNT_W-1:0] lo_q,
  output out_mode_e        mode_q
);

  // Reset value hi=0, lo=1 classifies as "hold low".
  localparam logic [CNT_W-1:0] RST_HI = '0;
  localparam logic [CNT_W-1:0] RST_LO = CNT_W'(1);

  logic [CNT_W-1:0] hi_d;
  logic [CNT_W-1:0] lo_d;
  out_mode_e        mode_d;

  always_comb begin
    hi_d   = hi_in;
    lo_d   = lo_in;
    mode_d = classify(hi_in == '0, lo_in == '0);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hi_q   <= RST_HI;
      lo_q   <= RST_LO;
      mode_q <= MODE_HOLD_LO;
    end else if (load) begin
      hi_q   <= hi_d;
      lo_q   <= lo_d;
      mode_q <= mode_d;
    end
  end

endmodule

// File: rtl/prog_clk_out_period.sv
module prog_clk_out_period
  import prog_clk_out_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] hi_in,
  input  logic [CNT_W-1:0] lo_in,
  input  logic [CNT_W-1:0] hi_q,
  input  logic [CNT_W-1:0] lo_q,
  input  out_mode_e        mode_q,
  output logic             period_end,
  output logic [CNT_W:0]   cnt_q,
  output logic             level_q
);

  localparam int SUM_W = CNT_W + 1;

  logic [SUM_W-1:0] total;
  logic [SUM_W-1:0] last_idx;
  logic [SUM_W-1:0] cnt_d;
  logic [CNT_W-1:0] hi_nx;
  logic [CNT_W-1:0] lo_nx;
  out_mode_e        mode_nx;
  logic             level_d;

  always_comb begin
    total      = SUM_W'(hi_q) + SUM_W'(lo_q);
    last_idx   = total - SUM_W'(1);
    period_end = (mode_q == MODE_DIVIDE) && (cnt_q == last_idx);
  end

  // Counts the next cycle will use, and the level it will drive.
  always_comb begin
    hi_nx   = load ? hi_in : hi_q;
    lo_nx   = load ? lo_in : lo_q;
    mode_nx = classify(hi_nx == '0, lo_nx == '0);
    cnt_d   = load ? '0 : cnt_q + SUM_W'(1);
    case (mode_nx)
      MODE_DIVIDE:  level_d = (cnt_d < SUM_W'(hi_nx));
      MODE_HOLD_HI: level_d = 1'b1;
      default:      level_d = 1'b0;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q   <= '0;
      level_q <= 1'b0;
    end else begin
      cnt_q   <= cnt_d;
      level_q <= level_d;
    end
  end

endmodule

// File: rtl/prog_clk_out.sv
module prog_clk_out
  import prog_clk_out_pkg::*;
#(
  parameter int CNT_W      = 8,
  parameter int SYNC_STAGE = 2
) (
  input  logic             clk_ref,
  input  logic             rst_n,
  input  logic [CNT_W-1:0] high_cnt,
  input  logic [CNT_W-1:0] low_cnt,
  input  logic             clk_out_en,
  input  logic             gpio_data,
  output logic             pin_out
);

  logic             rst_sync_n;
  logic             load;
  logic             period_end;
  logic [CNT_W-1:0] shadow_hi;
  logic [CNT_W-1:0] shadow_lo;
  out_mode_e        shadow_mode;
  logic [CNT_W:0]   phase_cnt;
  logic             div_level;
  logic             clk_sel;

  prog_clk_out_rst_sync #(.STAGES(SYNC_STAGE)) u_rst_sync (
    .clk         (clk_ref),
    .rst_async_n (rst_n),
    .rst_sync_n  (rst_sync_n)
  );

  // Every cycle is a boundary in the non-dividing settings.
  assign load = period_end || (shadow_mode != MODE_DIVIDE);

  prog_clk_out_shadow #(.CNT_W(CNT_W)) u_shadow (
    .clk    (clk_ref),
    .rst_n  (rst_sync_n),
    .load   (load),
    .hi_in  (high_cnt),
    .lo_in  (low_cnt),
    .hi_q   (shadow_hi),
    .lo_q   (shadow_lo),
    .mode_q (shadow_mode)
  );

  prog_clk_out_period #(.CNT_W(CNT_W)) u_period (
    .clk        (clk_ref),
    .rst_n      (rst_sync_n),
    .load       (load),
    .hi_in      (high_cnt),
    .lo_in      (low_cnt),
    .hi_q       (shadow_hi),
    .lo_q       (shadow_lo),
    .mode_q     (shadow_mode),
    .period_end (period_end),
    .cnt_q      (phase_cnt),
    .level_q    (div_level)
  );

  always_comb begin
    clk_sel = (shadow_mode == MODE_BYPASS) ? clk_ref : div_level;
    pin_out = clk_out_en ? clk_sel : gpio_data;
  end

endmodule

// File: rtl/prog_clk_out_chk.sv
module prog_clk_out_chk
  import prog_clk_out_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input logic             clk_ref,
  input logic             rst_n,
  input logic [CNT_W-1:0] hi_q,
  input logic [CNT_W-1:0] lo_q,
  input out_mode_e        mode_q,
  input logic [CNT_W:0]   cnt_q,
  input logic             level_q
);

  localparam int SUM_W = CNT_W + 1;
  logic [SUM_W-1:0] tot;
  assign tot = SUM_W'(hi_q) + SUM_W'(lo_q);

  AST_PHASE_IN_PERIOD: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_DIVIDE) |-> (cnt_q < tot)) else $error("phase count past period"); // R2

  AST_START_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_DIVIDE && cnt_q == '0) |-> level_q) else $error("period not starting high"); // R2

  AST_LOW_AFTER_HI: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_DIVIDE && cnt_q == SUM_W'(hi_q)) |-> !level_q) else $error("high phase too long"); // R2

  AST_HOLD_HIGH: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_HOLD_HI) |-> level_q) else $error("hold high broken"); // R5

  AST_HOLD_LOW: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_HOLD_LO) |-> !level_q) else $error("hold low broken"); // R5

  AST_SHADOW_STABLE: assert property (@(posedge clk_ref) disable iff (!rst_n)
    (mode_q == MODE_DIVIDE && cnt_q != tot - SUM_W'(1)) |=> ($stable(hi_q) && $stable(lo_q)))
    else $error("counts changed mid-period"); // R6

endmodule

bind prog_clk_out prog_clk_out_chk #(.CNT_W(CNT_W)) u_chk (
  .clk_ref (clk_ref),
  .rst_n   (rst_sync_n),
  .hi_q    (shadow_hi),
  .lo_q    (shadow_lo),
  .mode_q  (shadow_mode),
  .cnt_q   (phase_cnt),
  .level_q (div_level)
);

// File: tb/test_prog_clk_out.sv
module test_prog_clk_out;

  logic       clk_ref = 1'b0;
  logic       rst_n;
  logic [7:0] high_cnt;
  logic [7:0] low_cnt;
  logic       clk_out_en;
  logic       gpio_data;
  logic       pin_out;

  int checks = 0;
  int fails  = 0;
  logic s;

  always #4 clk_ref = ~clk_ref;

  prog_clk_out i_prog_clk_out (
    .clk_ref    (clk_ref),
    .rst_n      (rst_n),
    .high_cnt   (high_cnt),
    .low_cnt    (low_cnt),
    .clk_out_en (clk_out_en),
    .gpio_data  (gpio_data),
    .pin_out    (pin_out)
  );

  localparam int NV = 8;
  localparam logic [7:0] V_HI [NV] = '{8'd5, 8'd1, 8'd1, 8'd9, 8'd3, 8'd255, 8'd2, 8'd1};
  localparam logic [7:0] V_LO [NV] = '{8'd5, 8'd1, 8'd9, 8'd1, 8'd7, 8'd255, 8'd1, 8'd2};

  task automatic check(input string req, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  // Sample once per cycle, after the falling edge.
  task automatic tick();
    @(negedge clk_ref);
    #1;
    s = pin_out;
  endtask

  task automatic wait_rise();
    int n = 0;
    logic prev;
    tick();
    prev = s;
    do begin
      tick();
      n++;
      if (!prev && s) break;
      prev = s;
    end while (n < 3000);
  endtask

  // Run lengths of the period that starts at the current (high) sample.
  task automatic measure(output int hi_run, output int lo_run);
    hi_run = 0;
    lo_run = 0;
    while (s && hi_run < 3000) begin hi_run++; tick(); end
    while (!s && lo_run < 3000) begin lo_run++; tick(); end
  endtask

  task automatic set_cnt(input int h, input int l);
    high_cnt = 8'(h);
    low_cnt  = 8'(l);
  endtask

  initial begin
    #1_000_000;
    fails++;
    checks++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    int hr, lr;
    string tag;
    rst_n = 1'b0; clk_out_en = 1'b1; gpio_data = 1'b1;
    set_cnt(5, 5);
    repeat (3) tick();
    check("R8", "pin in reset, enabled", pin_out, 0);
    clk_out_en = 1'b0; #1;
    check("R7", "pin in reset, disabled", pin_out, 1);
    clk_out_en = 1'b1;
    rst_n = 1'b1;
    tick();
    check("R8", "pin after release", pin_out, 0);

    // Vector table: each setting measured over one full period.
    for (int i = 0; i < NV; i++) begin
      set_cnt(V_HI[i], V_LO[i]);
      wait_rise();
      measure(hr, lr);
      if (V_HI[i] == 8'd255) tag = "R4";
      else if (V_HI[i] == 8'd1 || V_LO[i] == 8'd1) tag = "R3";
      else tag = "R2";
      check(tag, $sformatf("high run %0d/%0d", V_HI[i], V_LO[i]), hr, V_HI[i]);
      check(tag, $sformatf("low run %0d/%0d", V_HI[i], V_LO[i]), lr, V_LO[i]);
    end

    // R5 hold levels
    set_cnt(4, 0);
    repeat (20) tick();
    begin
      int ones = 0;
      for (int k = 0; k < 20; k++) begin tick(); ones += int'(s); end
      check("R5", "hold high samples", ones, 20);
    end
    set_cnt(0, 4);
    repeat (3) tick();
    begin
      int ones = 0;
      for (int k = 0; k < 20; k++) begin tick(); ones += int'(s); end
      check("R5", "hold low samples", ones, 0);
    end

    // R9: from hold low, a new dividing setting starts at once, high first
    set_cnt(2, 3);
    tick(); check("R9", "first cycle", s, 1);
    tick(); check("R9", "second cycle", s, 1);
    tick(); check("R9", "third cycle", s, 0);

    // R1: bypass follows the reference in both phases
    set_cnt(0, 4);
    repeat (8) tick();
    set_cnt(0, 0);
    repeat (2) tick();
    for (int k = 0; k < 3; k++) begin
      @(posedge clk_ref); #1;
      check("R1", "bypass during high phase", pin_out, 1);
      @(negedge clk_ref); #1;
      check("R1", "bypass during low phase", pin_out, 0);
    end

    // R6: change counts after two high cycles of a 6/6 period
    set_cnt(6, 6);
    wait_rise();
    tick();
    set_cnt(2, 2);
    hr = 2;
    while (s && hr < 3000) begin tick(); if (s) hr++; end
    lr = 0;
    while (!s && lr < 3000) begin lr++; tick(); end
    check("R6", "old high run kept", hr, 6);
    check("R6", "old low run kept", lr, 6);
    measure(hr, lr);
    check("R6", "new high run", hr, 2);
    check("R6", "new low run", lr, 2);

    // R7: GPIO value while disabled, clock again when enabled
    clk_out_en = 1'b0;
    gpio_data  = 1'b0; tick(); check("R7", "gpio 0", s, 0);
    gpio_data  = 1'b1; tick(); check("R7", "gpio 1", s, 1);
    tick(); check("R7", "gpio 1 held", s, 1);
    clk_out_en = 1'b1;
    wait_rise();
    measure(hr, lr);
    check("R7", "clock back high run", hr, 2);
    check("R7", "clock back low run", lr, 2);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule